// File: doc/BRIEF.md
# User Trace Record Generator

This block lets privileged debug software inject its own records into an instruction trace stream. Software writes an arbitrary 32-bit word into a user data register. Each write that is allowed and accepted becomes one trace record. The record carries the written word and a one-bit record type, and it is offered downstream on a valid/ready interface. Reading a register returns the word last written to it.

The parameter `TWO_REGS` sets how many registers the block has. With one register, the record type is taken from the `type_sel` control input at the time of the write. With two registers, the register that was written sets the type. Access rules are checked elsewhere and arrive here as the `wr_permit` qualifier. Records wait in a small queue of `QDEPTH` entries (default 2). A record that finds no room is dropped, and a sticky flag records the loss.

Top module: `user_trace_rec`

## Requirements
- R1: After a synchronous active-low reset, `rec_valid` is 0, `overflow` is 0 and both register read-backs return 0.
- R2: Each permitted write that finds queue room produces exactly one record whose `rec_data` equals the written word. The record appears on `rec_valid` in the cycle after the write edge.
- R3: In the two-register build, a record from register 0 has `rec_type` = 0 (type UT1) and a record from register 1 has `rec_type` = 1 (type UT2).
- R4: In the single-register build, `rec_type` equals the value `type_sel` had on the write cycle. The `wr1_en` input is ignored, and reading index 1 returns 0.
- R5: A write with `wr_permit` = 0 is ignored. It changes no register and produces no record.
- R6: The queue holds `QDEPTH` records. A record is accepted when the queue has room, and a record popped in the same cycle frees its slot. A write that finds no room is dropped and sets `overflow`, which stays at 1 until reset.
- R7: `rd_data` returns the last permitted value written to the register chosen by `rd_sel` (0 = register 0, 1 = register 1).
- R8: While `rec_valid` = 1 and `rec_ready` = 0, `rec_valid`, `rec_type` and `rec_data` hold steady.
- R9: Writes to both registers in the same cycle are queued with the register 0 (UT1) record first and the register 1 (UT2) record second. If only one slot is free, the UT1 record takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_permit | input | 1 | Write allowed by access rules |
| wr0_en | input | 1 | Write strobe, register 0 |
| wr0_data | input | 32 | Write data, register 0 |
| wr1_en | input | 1 | Write strobe, register 1 (two-register build) |
| wr1_data | input | 32 | Write data, register 1 |
| type_sel | input | 1 | Record type for the single-register build |
| rd_sel | input | 1 | Register chosen for read-back |
| rd_data | output | 32 | Read-back value |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Downstream accepts record |
| rec_type | output | 1 | Record type (0 = UT1, 1 = UT2) |
| rec_data | output | 32 | Record payload |
| overflow | output | 1 | Sticky record-drop flag |

## Verification
The assertions check four properties on every cycle. The record output stays stable under back-pressure. The queue is never pushed beyond its free space, counting the slot freed by a same-cycle pop. The drop flag is sticky. Registers and the record stream do not change when `wr_permit` is low.

Other properties can only be shown by the bench's scenarios, which compare every cycle against an arithmetic queue model. These include the record type chosen by address or by `type_sel`, the UT1-before-UT2 order of paired writes, exactly which write is dropped when only one slot is free, and read-back values.

// File: rtl/utrc_pkg.sv
// Package: shared record types for the user trace record generator.
// Assumes the record type is a single bit.
package utrc_pkg;
    typedef enum logic {
        REC_UT1 = 1'b0,
        REC_UT2 = 1'b1
    } rec_type_e;
endpackage

// File: rtl/utrc_regs.sv
// Module: user data registers with read-back.
// Holds one or two registers, as chosen by TWO_REGS. A write lands only when
// wr_permit is high. An absent register reads as zero.
module utrc_regs #(
    parameter int DATA_W   = 32,
    parameter bit TWO_REGS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_permit,
    input  logic              wr0_en,
    input  logic [DATA_W-1:0] wr0_data,
    input  logic              wr1_en,
    input  logic [DATA_W-1:0] wr1_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] reg0_q;
    logic [DATA_W-1:0] reg1_q;

    // Register 0 storage: capture permitted writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                    reg0_q <= '0;
        else if (wr_permit && wr0_en)  reg0_q <= wr0_data;
    end

    generate
        if (TWO_REGS) begin : g_reg1
            // Register 1 storage: capture permitted writes.
            always_ff @(posedge clk) begin
                if (!rst_n)                    reg1_q <= '0;
                else if (wr_permit && wr1_en)  reg1_q <= wr1_data;
            end
        end else begin : g_noreg1
            assign reg1_q = '0;
        end
    endgenerate

    // Read-back multiplexer.
    always_comb rd_data = rd_sel ? reg1_q : reg0_q;

    // R5: unprivileged cycles leave stored values untouched.
    a_r5_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_permit |=> ($stable(reg0_q) && $stable(reg1_q)));
endmodule

// File: rtl/utrc_queue.sv
// Module: record queue with up to two pushes and one pop per cycle.
// Assumes DEPTH is a power of two and at least 2. The caller must never push
// more entries than the free space plus the entry popped in the same cycle.
module utrc_queue #(
    parameter int W     = 33,
    parameter int DEPTH = 2,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    push_n,
    input  logic [W-1:0]  push_d0,
    input  logic [W-1:0]  push_d1,
    input  logic          pop,
    output logic          not_empty,
    output logic [W-1:0]  head,
    output logic [CW-1:0] used
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            wptr <= wptr + AW'(push_n);
            if (pop) rptr <= rptr + AW'(1);
            cnt  <= cnt + CW'(push_n) - CW'(pop);
        end
    end

    // Entry storage: the first push goes to wptr, the second to the slot after it.
    always_ff @(posedge clk) begin
        if (push_n != 2'd0) mem[wptr] <= push_d0;
        if (push_n == 2'd2) mem[wptr + AW'(1)] <= push_d1;
    end

    assign not_empty = (cnt != '0);
    assign head      = mem[rptr];
    assign used      = cnt;

    // R6: pushes never exceed free space plus the slot freed by a same-cycle pop.
    a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cnt) + 32'(push_n) - 32'(pop)) <= DEPTH);

    // R6: never pop when empty.
    a_r6_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> not_empty);
endmodule

// File: rtl/user_trace_rec.sv
// Module: user trace record generator (top).
// Turns permitted register writes into typed trace records on a valid/ready
// output. Assumes wr_permit already reflects the access rules.
module user_trace_rec #(
    parameter int DATA_W   = 32,
    parameter bit TWO_REGS = 1'b1,
    parameter int QDEPTH   = 2,
    localparam int EW      = DATA_W + 1,
    localparam int CW      = $clog2(QDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_permit,
    input  logic              wr0_en,
    input  logic [DATA_W-1:0] wr0_data,
    input  logic              wr1_en,
    input  logic [DATA_W-1:0] wr1_data,
    input  logic              type_sel,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              rec_valid,
    input  logic              rec_ready,
    output logic              rec_type,
    output logic [DATA_W-1:0] rec_data,
    output logic              overflow
);
    import utrc_pkg::*;

    logic          req0, req1, acc0, acc1, drop, pop;
    logic [1:0]    push_n;
    logic [EW-1:0] ent0, ent1, first_ent, head;
    logic [CW-1:0] used;
    logic [CW:0]   room;
    rec_type_e     type0;
    logic          ovf_q;

    utrc_regs #(.DATA_W(DATA_W), .TWO_REGS(TWO_REGS)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_permit(wr_permit),
        .wr0_en(wr0_en), .wr0_data(wr0_data),
        .wr1_en(wr1_en), .wr1_data(wr1_data),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    // Type for register 0 records: fixed in the two-register build, from type_sel otherwise.
    generate
        if (TWO_REGS) begin : g_addr_type
            assign type0 = REC_UT1;
            assign req1  = wr_permit && wr1_en;
        end else begin : g_ctrl_type
            assign type0 = rec_type_e'(type_sel);
            assign req1  = 1'b0;
        end
    endgenerate

    // Accept requests in register order while room remains (a same-cycle pop frees a slot).
    always_comb begin
        req0      = wr_permit && wr0_en;
        pop       = rec_valid && rec_ready;
        room      = (CW+1)'(QDEPTH) - (CW+1)'(used) + (CW+1)'(pop);
        acc0      = req0 && (room >= (CW+1)'(1));
        acc1      = req1 && (room >= (req0 ? (CW+1)'(2) : (CW+1)'(1)));
        push_n    = {1'b0, acc0} + {1'b0, acc1};
        drop      = (req0 && !acc0) || (req1 && !acc1);
        ent0      = {type0, wr0_data};
        ent1      = {REC_UT2, wr1_data};
        first_ent = acc0 ? ent0 : ent1;
    end

    utrc_queue #(.W(EW), .DEPTH(QDEPTH)) queue_i (
        .clk(clk), .rst_n(rst_n), .push_n(push_n),
        .push_d0(first_ent), .push_d1(ent1), .pop(pop),
        .not_empty(rec_valid), .head(head), .used(used)
    );

    // Sticky drop flag.
    always_ff @(posedge clk) begin
        if (!rst_n)    ovf_q <= 1'b0;
        else if (drop) ovf_q <= 1'b1;
    end

    assign overflow = ovf_q;
    assign rec_type = head[EW-1];
    assign rec_data = head[DATA_W-1:0];

    // R8: a stalled record holds its contents.
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_type) && $stable(rec_data)));

    // R6: overflow stays set once raised.
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R5: with no permit and nothing queued, no record appears.
    a_r5_no_record_unpriv: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_permit && !rec_valid) |=> !rec_valid);
endmodule

// File: tb/user_trace_rec_tb_top.sv
// Bench: sweeps ready, permit and write patterns against an arithmetic queue model.
module user_trace_rec_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PHASE_LEN  = 500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_permit = 1'b0, wr0_en = 1'b0, wr1_en = 1'b0;
    logic [31:0] wr0_data = '0, wr1_data = '0;
    logic        type_sel = 1'b0, rd_sel = 1'b0, rec_ready = 1'b0;
    logic [31:0] rd_data, rec_data, s_rd_data, s_rec_data;
    logic        rec_valid, rec_type, overflow;
    logic        s_rec_valid, s_rec_type, s_overflow;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    user_trace_rec #(.TWO_REGS(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_permit(wr_permit),
        .wr0_en(wr0_en), .wr0_data(wr0_data), .wr1_en(wr1_en), .wr1_data(wr1_data),
        .type_sel(type_sel), .rd_sel(rd_sel), .rd_data(rd_data),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_type(rec_type),
        .rec_data(rec_data), .overflow(overflow));

    user_trace_rec #(.TWO_REGS(1'b0)) dut1_i (
        .clk(clk), .rst_n(rst_n), .wr_permit(wr_permit),
        .wr0_en(wr0_en), .wr0_data(wr0_data), .wr1_en(wr1_en), .wr1_data(wr1_data),
        .type_sel(type_sel), .rd_sel(rd_sel), .rd_data(s_rd_data),
        .rec_valid(s_rec_valid), .rec_ready(1'b1), .rec_type(s_rec_type),
        .rec_data(s_rec_data), .overflow(s_overflow));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Model state for the two-register build.
    logic        mq_t [2];
    logic [31:0] mq_d [2];
    int          mcnt = 0;
    logic        movf = 1'b0;
    logic [31:0] mreg [2];
    // Model state for the single-register build (ready always high).
    logic        p_valid = 1'b0, p_type = 1'b0;
    logic [31:0] p_data = '0;

    task automatic mpush(input logic t, input logic [31:0] d);
        if (mcnt < 2) begin
            mq_t[mcnt] = t;
            mq_d[mcnt] = d;
            mcnt++;
        end else begin
            movf = 1'b1;
        end
    endtask

    // Per-cycle compare at the negedge, then drive and advance the model.
    task automatic cycle(input int ready_pct, input int permit_pct);
        @(negedge clk);
        check("R2/R6 valid", 64'(rec_valid), 64'(mcnt > 0));
        if (mcnt > 0) begin
            check("R3/R9 type", 64'(rec_type), 64'(mq_t[0]));
            check("R2 data", 64'(rec_data), 64'(mq_d[0]));
        end
        check("R6 overflow", 64'(overflow), 64'(movf));
        check("R7 readback", 64'(rd_data), 64'(mreg[rd_sel]));
        check("R4 single valid", 64'(s_rec_valid), 64'(p_valid));
        if (p_valid) begin
            check("R4 single type", 64'(s_rec_type), 64'(p_type));
            check("R4 single data", 64'(s_rec_data), 64'(p_data));
        end
        check("R4 single read", 64'(s_rd_data), rd_sel ? 64'(0) : 64'(mreg[0]));
        check("R4 single ovf", 64'(s_overflow), 64'(0));
        // new stimulus
        rec_ready = (($urandom % 100) < 32'(ready_pct));
        wr_permit = (($urandom % 100) < 32'(permit_pct));
        wr0_en    = $urandom % 2 == 0;
        wr1_en    = $urandom % 2 == 0;
        wr0_data  = $urandom;
        wr1_data  = $urandom;
        type_sel  = $urandom % 2 == 0;
        rd_sel    = $urandom % 2 == 0;
        // model: pop, then R9 order push, then registers
        if (mcnt > 0 && rec_ready) begin
            mq_t[0] = mq_t[1];
            mq_d[0] = mq_d[1];
            mcnt--;
        end
        if (wr_permit && wr0_en) begin mpush(1'b0, wr0_data); mreg[0] = wr0_data; end
        if (wr_permit && wr1_en) begin mpush(1'b1, wr1_data); mreg[1] = wr1_data; end
        p_valid = wr_permit && wr0_en;
        p_type  = type_sel;
        p_data  = wr0_data;
    endtask

    initial begin
        mreg[0] = '0;
        mreg[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 valid", 64'(rec_valid), 64'(0));
        check("R1 overflow", 64'(overflow), 64'(0));
        check("R1 read0", 64'(rd_data), 64'(0));
        rd_sel = 1'b1;
        #1 check("R1 read1", 64'(rd_data), 64'(0));
        rd_sel = 1'b0;
        // sweep ready and permit rates; R5 covered by permit=0 phase, R8 by stalls
        for (int rp = 0; rp <= 100; rp += 50) begin
            for (int pp = 0; pp <= 100; pp += 50) begin
                // restart from reset so overflow stickiness is visible per phase
                @(negedge clk);
                rst_n = 1'b0;
                @(negedge clk);
                rst_n = 1'b1;
                mcnt = 0; movf = 1'b0; mreg[0] = '0; mreg[1] = '0;
                p_valid = 1'b0;
                wr_permit = 1'b0; wr0_en = 1'b0; wr1_en = 1'b0;
                for (int i = 0; i < PHASE_LEN; i++) cycle(rp, pp);
            end
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule